// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with a single data bus that carries both read and write data. A command (read, write, or deselect) is presented on the address and control inputs at a rising clock edge. Its data moves over the bus two enabled edges later, whether the command is a read or a write. Because both kinds of command put their data on the bus at the same point in the schedule, a controller can mix reads and writes freely, one per clock, without inserting idle cycles when the direction changes.

The data bus is split into an input, an output and an output-drive flag so that the pad tristate sits outside the block. Three chip enables select the device. Per-byte write strobes mask write data. An advance/load input runs four-beat bursts in linear or interleaved order. A clock enable freezes every stage of the pipeline. An asynchronous output enable gates the drive flag. The word array is an inferred register array. Its depth is a parameter, and the low address bits select the word.

Top module: `zt_sram`

## Requirements
- R1: The array holds WORDS words of DW bits. A word is selected by the low $clog2(WORDS) bits of `addr`, so two addresses that differ only above those bits refer to the same word.
- R2: A read captured at enabled edge k shows its word on `dq_out` with `dq_drive` high from just after enabled edge k+1 until enabled edge k+2.
- R3: Reads, writes and deselects can be issued in any mix on consecutive enabled edges, and every one of them is carried out with no idle cycle between them.
- R4: While `clk_en` is low, no pipeline stage, burst counter or array word changes, `dq_in` is ignored, and `dq_out` and `dq_drive` hold their values.
- R5: For a write captured at enabled edge k, `dq_in` and `bw_n` are sampled at enabled edge k+2. Byte lane i, bits 8i+7 down to 8i, is written only when `bw_n[i]` is 0.
- R6: A load (`adv_ld` = 0) is accepted only when `ce1_n` = 0, `ce2` = 1 and `ce3_n` = 0. Any other combination is a deselect, which writes nothing and drives nothing. `we_n` = 0 selects a write and `we_n` = 1 selects a read.
- R7: `dq_drive` is low during the data phase of a write and during the data phase of a deselect.
- R8: With `adv_ld` = 1, the block repeats the type of the last loaded command at the next burst address and keeps the upper address bits. The low two bits become start+k mod 4 when `burst_il` = 0, or start XOR k when `burst_il` = 1, for beat k = 1, 2, 3 and then wrapping to 0. An advance that follows a deselect load is itself a deselect.
- R9: `oe_n` = 1 forces `dq_drive` low in the same cycle and has no effect on the pipeline.
- R10: A read issued on the edge after a write to the same word returns the newly written bytes merged with the unwritten ones.
- R11: After reset the pipeline is empty, `dq_drive` is low, and an advance before any load is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; low freezes the block |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| burst_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | 0 write, 1 read |
| bw_n | input | DW/8 | Per-lane write strobes, active low, taken in the data phase |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DW | Data bus, inbound side |
| dq_out | output | DW | Data bus, outbound side |
| dq_drive | output | 1 | High when the block drives the data bus |

## Verification
The bench builds the block with AW = 8 and WORDS = 16. This makes every word reachable in a full write and read-back sweep, and addresses above bit 3 alias onto words already written. The small array also allows all 16 strobe patterns, all 8 chip-enable combinations, and every burst start in both orders to be swept one after another. Back-to-back write-then-read pairs and freezes placed in the middle of the stream exercise the forwarding path and the hold behaviour against a word-level model.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WORDS = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            adv_ld,
  input  logic            burst_il,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            ce3_n,
  input  logic            we_n,
  input  logic [DW/8-1:0] bw_n,
  input  logic [AW-1:0]   addr,
  input  logic            oe_n,
  input  logic [DW-1:0]   dq_in,
  output logic [DW-1:0]   dq_out,
  output logic            dq_drive
);
  localparam int NB = DW / 8;
  localparam int IW = $clog2(WORDS);

  localparam logic [1:0] OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] base, s1_a, s2_a;
  logic [1:0]    beat, last_op;
  logic          s1_v, s1_wr, s2_v, s2_wr;
  logic [DW-1:0] rd_q, rd_word;

  wire           sel   = !ce1_n && ce2 && !ce3_n;
  wire [1:0]     nbeat = beat + 2'd1;
  wire [1:0]     lo    = burst_il ? (base[1:0] ^ nbeat) : (base[1:0] + nbeat);
  wire [1:0]     op    = adv_ld ? last_op : (sel ? (we_n ? OP_RD : OP_WR) : OP_NONE);
  wire [AW-1:0]  a_eff = adv_ld ? {base[AW-1:2], lo} : addr;
  wire           wr_now = s2_v && s2_wr;
  wire           fwd    = wr_now && (s2_a[IW-1:0] == s1_a[IW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0; beat <= '0; last_op <= OP_NONE;
      s1_v <= 1'b0; s1_wr <= 1'b0; s1_a <= '0;
      s2_v <= 1'b0; s2_wr <= 1'b0; s2_a <= '0;
      rd_q <= '0;
    end else if (clk_en) begin
      if (!adv_ld) begin
        base    <= addr;
        beat    <= 2'd0;
        last_op <= op;
      end else begin
        beat <= nbeat;
      end
      s1_v  <= (op != OP_NONE);
      s1_wr <= (op == OP_WR);
      s1_a  <= a_eff;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      rd_q  <= rd_word;
    end
  end

  always_comb begin
    rd_word = mem[s1_a[IW-1:0]];
    for (int i = 0; i < NB; i++)
      if (fwd && !bw_n[i]) rd_word[8*i +: 8] = dq_in[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (clk_en && wr_now)
      for (int i = 0; i < NB; i++)
        if (!bw_n[i]) mem[s2_a[IW-1:0]][8*i +: 8] <= dq_in[8*i +: 8];
  end

  assign dq_out   = rd_q;
  assign dq_drive = s2_v && !s2_wr && !oe_n;

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_ld && !sel) |=> !s1_v); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(s1_a) && $stable(s2_v) && $stable(beat) && $stable(dq_out))); // R4
  AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> (s2_wr == $past(s1_wr) && s2_a == $past(s1_a))); // R3
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |-> !dq_drive); // R7
  AST_BURST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_ld) |=> (s1_a[AW-1:2] == $past(base[AW-1:2]))); // R8
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, adv_ld = 1'b0, burst_il = 1'b0;
  logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [3:0]  bw_n = 4'hf;
  logic [7:0]  addr = '0;
  logic [31:0] dq_in = '0, dq_out;
  logic        dq_drive;
  int checks = 0, errors = 0, n = 0;

  logic [31:0] mm [16];
  logic [7:0]  base_m = '0;
  logic [1:0]  beat_m = '0;
  int          last_m = 0;
  int          pk [4];
  logic [31:0] pd [4], pe [4];
  logic [3:0]  pb [4];
  logic        po [4];
  string       pt [4];

  always #2.5 clk = ~clk;

  zt_sram #(.AW(8), .DW(32), .WORDS(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld), .burst_il(burst_il),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive));

  task automatic chk(input bit ok, input string r, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic cyc(input bit adv, input logic [7:0] a, input logic [2:0] ce, input bit wr,
                     input logic [3:0] bwn, input logic [31:0] d, input bit oen, input string tag);
    int p, s, k;
    logic [7:0] ea;
    p = (n + 2) % 4;
    s = n % 4;
    if (pk[p] == 2) begin dq_in = pd[p]; bw_n = pb[p]; end
    else begin dq_in = 32'hDEAD_BEEF; bw_n = 4'h0; end
    oe_n = po[p];
    if (!adv) begin
      k = (ce == 3'b010) ? (wr ? 2 : 1) : 0;
      ea = a; base_m = a; beat_m = 2'd0; last_m = k;
    end else begin
      k = last_m;
      beat_m = beat_m + 2'd1;
      ea = {base_m[7:2], burst_il ? (base_m[1:0] ^ beat_m) : (base_m[1:0] + beat_m)};
    end
    pk[s] = k; pd[s] = d; pb[s] = bwn; po[s] = oen; pt[s] = tag;
    if (k == 2)
      for (int l = 0; l < 4; l++) if (!bwn[l]) mm[ea[3:0]][8*l +: 8] = d[8*l +: 8];
    if (k == 1) pe[s] = mm[ea[3:0]];
    adv_ld = adv; addr = a; {ce1_n, ce2, ce3_n} = ce; we_n = !wr;
    #1;
    if (pk[p] == 1 && !po[p])
      chk(dq_drive && dq_out == pe[p], pt[p], {dq_drive, dq_out}, {1'b1, pe[p]});
    else
      chk(!dq_drive, (pk[p] == 2) ? "R7" : pt[p], {32'd0, dq_drive}, 33'd0);
    @(posedge clk); @(negedge clk);
    n++;
  endtask

  task automatic wr_op(input logic [7:0] a, input logic [31:0] d, input logic [3:0] bwn, input string t);
    cyc(1'b0, a, 3'b010, 1'b1, bwn, d, 1'b0, t);
  endtask
  task automatic rd_op(input logic [7:0] a, input string t);
    cyc(1'b0, a, 3'b010, 1'b0, 4'hf, 32'h0, 1'b0, t);
  endtask
  task automatic nop();
    cyc(1'b0, 8'h0, 3'b000, 1'b0, 4'hf, 32'h0, 1'b0, "R7");
  endtask

  task automatic stall(input int k);
    logic [31:0] o; logic dv, od;
    logic [31:0] keep;
    o = dq_out; dv = dq_drive; keep = dq_in;
    clk_en = 1'b0;
    dq_in = ~keep;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
      od = dq_drive;
      chk(dq_out == o && od == dv, "R4", {od, dq_out}, {dv, o});
    end
    dq_in = keep;
    clk_en = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin pk[i] = 0; po[i] = 1'b0; pt[i] = "R11"; pe[i] = '0; pd[i] = '0; pb[i] = 4'hf; end
    for (int i = 0; i < 16; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dq_drive, "R11", {32'd0, dq_drive}, 33'd0);
    rst_n = 1'b1;
    cyc(1'b1, 8'h0, 3'b010, 1'b1, 4'h0, 32'h1234_5678, 1'b0, "R11");
    cyc(1'b1, 8'h0, 3'b010, 1'b0, 4'hf, 32'h0, 1'b0, "R11");
    for (int i = 0; i < 16; i++) wr_op(8'(i), 32'hA500_0000 ^ (i * 32'h0103_0507), 4'h0, "R1");
    for (int i = 0; i < 16; i++) rd_op(8'(i), "R2");
    for (int i = 0; i < 16; i++) rd_op(8'(i + 16 * (i % 15 + 1)), "R1");
    for (int i = 0; i < 16; i++) begin
      wr_op(8'((i * 5) % 16), 32'h5A5A_0000 + i * 32'h0011_0203, 4'h0, "R10");
      rd_op(8'((i * 5) % 16), "R10");
      rd_op(8'((i * 3) % 16), "R3");
    end
    for (int m = 0; m < 16; m++) begin
      wr_op(8'h3, 32'hC0C1_C2C3 + m * 32'h0404_0404, 4'(m), "R5");
      rd_op(8'h3, "R5");
    end
    for (int c = 0; c < 8; c++) begin
      cyc(1'b0, 8'h7, 3'(c), 1'b1, 4'h0, 32'h7700_0000 + c, 1'b0, "R6");
      cyc(1'b0, 8'h7, 3'(c), 1'b0, 4'hf, 32'h0, 1'b0, "R6");
      rd_op(8'h7, "R6");
      cyc(1'b1, 8'h0, 3'b010, 1'b0, 4'hf, 32'h0, 1'b0, "R8");
    end
    rd_op(8'h5, "R9");
    cyc(1'b0, 8'h5, 3'b010, 1'b0, 4'hf, 32'h0, 1'b1, "R9");
    rd_op(8'h5, "R9");
    for (int il = 0; il < 2; il++) begin
      burst_il = il[0];
      for (int st = 0; st < 4; st++) begin
        wr_op(8'(8 + st), 32'hB000_0000 + il * 32'h100 + st * 32'h10, 4'h0, "R8");
        for (int b = 1; b < 4; b++)
          cyc(1'b1, 8'h0, 3'b000, 1'b0, 4'h0, 32'hB000_0000 + il * 32'h100 + st * 32'h10 + b, 1'b0, "R8");
        for (int w = 8; w < 12; w++) rd_op(8'(w), "R8");
        rd_op(8'(8 + st), "R8");
        for (int b = 1; b < 5; b++) cyc(1'b1, 8'h0, 3'b000, 1'b1, 4'hf, 32'h0, 1'b0, "R8");
      end
    end
    wr_op(8'h2, 32'hFACE_0001, 4'h0, "R4");
    rd_op(8'h2, "R4");
    stall(3);
    wr_op(8'h2, 32'h0BAD_F00D, 4'h0, "R4");
    stall(2);
    rd_op(8'h2, "R4");
    stall(2);
    rd_op(8'h1, "R4");
    nop(); nop(); nop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule